// File: doc/BRIEF.md
# Bus-Mastering Block Copy Engine (Memory to Device)

This engine copies a block of words out of memory into a device data port without the processor handling any of the data. Software first programs two values through a small configuration port: the first memory address of the block and the number of words to move. It then issues a go command. The engine raises a bus request and waits for the processor to grant the bus. After the grant it acts as bus master. It issues one memory read per cycle at consecutive addresses and forwards each returned word to the device. A separate word counter is decremented as each word reaches the device.

When the word counter reaches zero, the engine drops its bus request and raises a one-cycle completion pulse. It then returns to idle. A go command with a zero word count finishes at once and never asks for the bus. Both programmed values are held across transfers, so issuing go again repeats the same block.

Top module: `dma_block_xfer`

## Requirements
- R1: After reset, bus_req, mem_rd_en, dev_wr_en, done and busy are all low.
- R2: A go command (cfg_we with cfg_sel = 2) with a nonzero count raises bus_req in the next cycle. No memory read is issued until bus_ack has been high at a clock edge while bus_req is high, and the first read follows in the cycle after that edge.
- R3: After the grant, exactly count reads are issued, one per cycle, in consecutive cycles. Their addresses run from the start address upward in steps of one.
- R4: Read data returns one cycle after the read is issued. The matching device write (dev_wr_en with dev_wdata) occurs in the cycle after that, two cycles after the read, and writes keep the order of the reads.
- R5: The word count drops by one for each device write, and exactly count device writes are made per transfer.
- R6: In the cycle after the last device write, done is high for exactly one cycle and bus_req is low. In the cycle after that, busy is low.
- R7: A go command with a count of zero gives a done pulse in the next cycle, and bus_req stays low throughout.
- R8: Configuration writes and go commands made while busy is high are ignored. The running transfer is unaffected, and the stored start address stays as it was.
- R9: The start address (cfg_sel = 0) and the word count (cfg_sel = 1) stay stored after a transfer. A later go without reloading repeats the same block.
- R10: Memory addresses wrap modulo 2^AW when the block crosses the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 start address, 1 word count, 2 go |
| cfg_wdata | input | CFG_W | Configuration write value |
| bus_req | output | 1 | Request for bus ownership |
| bus_ack | input | 1 | Bus grant from the processor |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after mem_rd_en |
| dev_wr_en | output | 1 | Device write strobe |
| dev_wdata | output | DW | Data written to the device |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted state register or counter is visible at the ports within a few cycles. A read counter that is off by one changes the number of mem_rd_en pulses, and this shows before done. A wrong word counter moves the done pulse away from the cycle after the last device write, or makes it repeat. A broken address step shows on mem_addr at the second read. A read issued ahead of the grant shows in the same cycle as mem_rd_en high while bus_ack is low. A wrong pipeline depth shifts dev_wr_en relative to mem_rd_en by one cycle, and device data that does not match the model of the addressed word reveals a misaligned data register.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_REQUEST  = 2'd1,
    ST_TRANSFER = 2'd2,
    ST_RELEASE  = 2'd3
  } dma_state_t;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_GO    = 2'd2;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             busy,
  output logic [AW-1:0]    start_addr,
  output logic [CW-1:0]    word_cnt,
  output logic             go
);
  import dma_pkg::*;

  logic wr_ok;
  assign wr_ok = cfg_we && !busy;
  assign go    = wr_ok && (cfg_sel == SEL_GO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_addr <= '0;
      word_cnt   <= '0;
    end else if (wr_ok) begin
      if (cfg_sel == SEL_ADDR)  start_addr <= cfg_wdata[AW-1:0];
      if (cfg_sel == SEL_COUNT) word_cnt   <= cfg_wdata[CW-1:0];
    end
  end
endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               cnt_zero,
  input  logic               bus_ack,
  input  logic               last_wr,
  output dma_pkg::dma_state_t state,
  output logic               load,
  output logic               bus_req,
  output logic               in_xfer,
  output logic               busy,
  output logic               done
);
  import dma_pkg::*;

  dma_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (go) nxt = cnt_zero ? ST_RELEASE : ST_REQUEST;
      ST_REQUEST:  if (bus_ack) nxt = ST_TRANSFER;
      ST_TRANSFER: if (last_wr) nxt = ST_RELEASE;
      ST_RELEASE:  nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign load    = go && (state == ST_IDLE) && !cnt_zero;
  assign bus_req = (state == ST_REQUEST) || (state == ST_TRANSFER);
  assign in_xfer = (state == ST_TRANSFER);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_RELEASE);
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_cnt,
  input  logic          in_xfer,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  output logic          dev_wr_en,
  output logic [DW-1:0] dev_wdata,
  output logic          wc_tick,
  output logic          last_wr
);
  localparam logic [AW-1:0] ADDR_STEP = AW'(1);
  localparam logic [CW-1:0] CNT_ONE   = CW'(1);

  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return a + ADDR_STEP;
  endfunction

  function automatic logic [CW-1:0] cnt_dec(input logic [CW-1:0] c);
    return c - CNT_ONE;
  endfunction

  logic [AW-1:0] cur_addr;
  logic [CW-1:0] rd_left;
  logic [CW-1:0] wc_left;
  logic          rvalid_q;
  logic          wr_q;
  logic [DW-1:0] data_q;

  assign mem_rd_en = in_xfer && (rd_left != '0);
  assign mem_addr  = cur_addr;
  assign dev_wr_en = wr_q;
  assign dev_wdata = data_q;
  assign wc_tick   = wr_q;
  assign last_wr   = wc_tick && (wc_left == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      rd_left  <= '0;
    end else if (load) begin
      cur_addr <= start_addr;
      rd_left  <= word_cnt;
    end else if (mem_rd_en) begin
      cur_addr <= addr_next(cur_addr);
      rd_left  <= cnt_dec(rd_left);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wc_left <= '0;
    else if (load)    wc_left <= word_cnt;
    else if (wc_tick) wc_left <= cnt_dec(wc_left);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      wr_q     <= 1'b0;
      data_q   <= '0;
    end else begin
      rvalid_q <= mem_rd_en;
      wr_q     <= rvalid_q;
      if (rvalid_q) data_q <= mem_rdata;
    end
  end
endmodule

// File: rtl/dma_block_xfer.sv
module dma_block_xfer #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DW    = 32,
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             bus_req,
  input  logic             bus_ack,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic             dev_wr_en,
  output logic [DW-1:0]    dev_wdata,
  output logic             busy,
  output logic             done
);
  logic [AW-1:0] start_addr;
  logic [CW-1:0] word_cnt;
  logic          go;
  logic          cnt_zero;
  logic          go_zero;
  logic          load;
  logic          in_xfer;
  logic          wc_tick;
  logic          last_wr;
  dma_pkg::dma_state_t state;

  assign cnt_zero = (word_cnt == '0);
  assign go_zero  = go && cnt_zero;

  dma_cfg_regs #(.AW(AW), .CW(CW), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .start_addr(start_addr),
    .word_cnt(word_cnt), .go(go)
  );

  dma_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero),
    .bus_ack(bus_ack), .last_wr(last_wr), .state(state), .load(load),
    .bus_req(bus_req), .in_xfer(in_xfer), .busy(busy), .done(done)
  );

  dma_datapath #(.AW(AW), .CW(CW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
    .word_cnt(word_cnt), .in_xfer(in_xfer), .mem_rdata(mem_rdata),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .dev_wr_en(dev_wr_en),
    .dev_wdata(dev_wdata), .wc_tick(wc_tick), .last_wr(last_wr)
  );
endmodule

// File: rtl/dma_xfer_chk.sv
module dma_xfer_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_addr,
  input logic          dev_wr_en,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] start_addr,
  input logic [CW-1:0] word_cnt,
  input logic          go_zero
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !bus_req && !mem_rd_en && !done);

  // R2
  read_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> bus_req && $past(bus_ack));

  // R2
  req_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !mem_rd_en);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && $past(mem_rd_en) |-> mem_addr == AW'($past(mem_addr) + 1'b1));

  // R4
  write_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr_en |-> $past(mem_rd_en, 2));

  // R6
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R7
  zero_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_zero |=> done && !bus_req);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(start_addr) && $stable(word_cnt));
endmodule

bind dma_block_xfer dma_xfer_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .dev_wr_en(dev_wr_en),
  .busy(busy), .done(done), .start_addr(start_addr), .word_cnt(word_cnt),
  .go_zero(go_zero)
);

// File: tb/tb_dma_block_xfer.sv
module tb_dma_block_xfer;
  localparam int AW = 16, CW = 16, DW = 32, CFG_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic bus_ack = 1'b0;
  logic bus_req, mem_rd_en, dev_wr_en, busy, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] dev_wdata;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dma_block_xfer #(.AW(AW), .CW(CW), .DW(DW), .CFG_W(CFG_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_ack(bus_ack),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dev_wr_en(dev_wr_en), .dev_wdata(dev_wdata), .busy(busy), .done(done)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction

  // memory with one-cycle read latency
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_word(mem_addr);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [CFG_W-1:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic test_reset();
    check("R1 bus_req", bus_req, 0);
    check("R1 mem_rd_en", mem_rd_en, 0);
    check("R1 dev_wr_en", dev_wr_en, 0);
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
  endtask

  // load (optional), go, grant after ack_dly cycles, collect and check
  task automatic run_xfer(input string name, input bit do_load, input logic [AW-1:0] a,
                          input int n, input int ack_dly, input bit poke);
    logic [AW-1:0] rd_a[32];
    int rd_c[32];
    logic [DW-1:0] wr_d[32];
    int wr_c[32];
    int nr = 0, nw = 0, nd = 0, req_cyc = -1, done_c = -1, bad_grant = 0;
    int req_at_done = 0, busy_after = 1, poke_step = 0, req_before_last = 0;
    if (do_load) begin
      cfg_write(2'd0, CFG_W'(a));
      cfg_write(2'd1, CFG_W'(n));
    end
    cfg_write(2'd2, '0);
    for (int cyc = 0; cyc < 300; cyc++) begin
      if (bus_req && req_cyc < 0) req_cyc = cyc;
      if (mem_rd_en) begin
        if (!bus_ack) bad_grant++;
        if (nr < 32) begin rd_a[nr] = mem_addr; rd_c[nr] = cyc; end
        nr++;
      end
      if (dev_wr_en) begin
        if (nw < 32) begin wr_d[nw] = dev_wdata; wr_c[nw] = cyc; end
        if (nw == n - 1 && bus_req) req_before_last = 1;
        nw++;
      end
      if (done) begin
        nd++;
        if (done_c < 0) done_c = cyc;
        if (bus_req) req_at_done++;
      end
      if (done_c >= 0 && cyc == done_c + 1) begin
        busy_after = busy;
        if (done) nd++;
        break;
      end
      bus_ack = bus_req && req_cyc >= 0 && (cyc >= req_cyc + ack_dly);
      if (poke) begin
        if (poke_step == 0 && nr >= 1) begin
          cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h7777; poke_step = 1;
        end else if (poke_step == 1) begin
          cfg_we = 1'b1; cfg_sel = 2'd2; poke_step = 2;
        end else if (poke_step == 2) begin
          cfg_we = 1'b0; poke_step = 3;
        end
      end
      @(negedge clk);
    end
    bus_ack = 1'b0;
    cfg_we = 1'b0;
    @(negedge clk);
    check({name, " R2 req next cycle"}, 64'(req_cyc), 0);
    check({name, " R2 no read before grant"}, 64'(bad_grant), 0);
    if (nr > 0) check({name, " R2 first read after grant"}, 64'(rd_c[0]), 64'(ack_dly + 1));
    check({name, " R3 read count"}, 64'(nr), 64'(n));
    for (int i = 0; i < n && i < nr && i < 32; i++) begin
      check({name, " R3 R10 read addr"}, 64'(rd_a[i]), 64'(AW'(a + AW'(i))));
      check({name, " R3 read cycle"}, 64'(rd_c[i]), 64'(rd_c[0] + i));
    end
    check({name, " R5 write count"}, 64'(nw), 64'(n));
    for (int i = 0; i < n && i < nw && i < nr && i < 32; i++) begin
      check({name, " R4 write cycle"}, 64'(wr_c[i]), 64'(rd_c[i] + 2));
      check({name, " R4 write data"}, 64'(wr_d[i]), 64'(mem_word(AW'(a + AW'(i)))));
    end
    check({name, " R6 one done pulse"}, 64'(nd), 1);
    if (nw > 0 && nw <= 32) check({name, " R6 done after last write"}, 64'(done_c), 64'(wr_c[nw-1] + 1));
    check({name, " R6 req held to last write"}, 64'(req_before_last), 1);
    check({name, " R6 req low at done"}, 64'(req_at_done), 0);
    check({name, " R6 idle after done"}, 64'(busy_after), 0);
  endtask

  task automatic test_zero_count();
    int req_seen = 0;
    cfg_write(2'd1, '0);
    cfg_write(2'd2, '0);
    check("R7 done next cycle", done, 1);
    check("R7 no request", bus_req, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (bus_req) req_seen++;
      if (i == 0) check("R7 done single cycle", done, 0);
    end
    check("R7 bus never requested", 64'(req_seen), 0);
    check("R7 no reads", mem_rd_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_xfer("basic", 1'b1, 16'h0100, 4, 0, 1'b0);
    run_xfer("slow_grant", 1'b1, 16'h0A00, 1, 5, 1'b0);
    run_xfer("wrap", 1'b1, 16'hFFFD, 6, 2, 1'b0);
    test_zero_count();
    run_xfer("busy_poke R8", 1'b1, 16'h0040, 5, 1, 1'b1);
    // R9: repeat without reload, R8: poked address must not have stuck
    run_xfer("repeat R9", 1'b0, 16'h0040, 5, 0, 1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule